// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block collects interrupt events from a set of sources and keeps them until software deals with them. Each source has its own bit, and that bit sits at the same index in every register of the bank. A one-cycle event pulse sets the source's cause bit. A mask bit can hide the source. The single interrupt output goes high when at least one cause bit is set and not masked.

Software reaches the bank through a simple port with word address, write data, a write strobe, a read strobe and registered read data. A per-bit mode register chooses how each cause bit is cleared, and software can change it at run time. A bit in mode 0 is cleared by writing a one to it. A bit in mode 1 is cleared when a read returns it as one. Software can also raise causes itself. The mask can be written as a whole, or changed one bit at a time through separate set and clear aliases. When the mask is set, a cause is still latched but it cannot drive the output.

Top module: `irq_cause_bank`

## Requirements
- R1: Word offsets decode as follows: 0 is mode, 1 is raw cause, 2 is masked cause, 3 is cause-set, 4 is mask, 5 is mask-set and 6 is mask-clear. The mode register reads back the value last written to it.
- R2: After reset, every cause bit is 0, every mask bit is 1, every mode bit is 0 and the interrupt output is low.
- R3: A write to offset 1 or offset 2 clears each cause bit that is written as 1 and is in mode 0. Writes have no effect on bits in mode 1.
- R4: A read of offset 1 clears each cause bit that is returned as 1 and is in mode 1. Reads have no effect on bits in mode 0.
- R5: A read of offset 2 returns cause AND NOT mask. It clears only those returned bits that are in mode 1.
- R6: Writing a 1 to a bit at offset 3 sets that cause bit. Reading offset 3 returns 0.
- R7: Offset 4 is read and written directly. A 1 written at offset 5 sets that mask bit. A 1 written at offset 6 clears that mask bit. Zero bits leave the mask unchanged. Reads of offsets 5 and 6 return 0.
- R8: An event pulse sets its cause bit on the next clock edge. If the same bit is cleared in the same cycle, by a write or by a read, the event wins and the bit stays set.
- R9: The interrupt output is a register. After every clock edge it equals the OR of cause AND NOT mask, as those registers hold after that edge.
- R10: Read data is registered and appears in the cycle after the read strobe. A read of any offset above 6 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | NUM_SRC | Event pulses, one per source |
| addr_i | input | ADDR_W | Register word offset |
| wr_data_i | input | NUM_SRC | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | NUM_SRC | Read data, valid the cycle after rd_en_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the bank with NUM_SRC = 12 and ADDR_W = 4. The narrower source count checks that the reset value of all ones and every per-bit path scale with the parameter rather than assuming 32 bits. The extra address bit lets the bench read offset 7 and offsets beyond 7, and confirm that they return zero. The directed scenarios mix modes inside one word, so that a single read or write reaches mode-0 and mode-1 bits, masked and unmasked bits, and an event that collides with a clear, all at once.

// File: rtl/irq_bank_pkg.sv
// Package: register offsets and select vector shared by the bank.
// Assumes word addressing; offsets fit in three bits.
package irq_bank_pkg;

    typedef enum logic [2:0] {
        OFS_MODE   = 3'd0,
        OFS_CAUSE  = 3'd1,
        OFS_MCAUSE = 3'd2,
        OFS_SET    = 3'd3,
        OFS_MASK   = 3'd4,
        OFS_MSET   = 3'd5,
        OFS_MCLR   = 3'd6
    } reg_ofs_e;

    // One strobe per register; at most one set at a time.
    typedef struct packed {
        logic mode;
        logic cause;
        logic mcause;
        logic set;
        logic mask;
        logic mset;
        logic mclr;
    } reg_sel_t;

    localparam reg_sel_t SEL_NONE = '0;

endpackage

// File: rtl/irq_bank_decode.sv
// Module: irq_bank_decode
// Turns a word offset plus strobe into a one-hot register select.
// Assumes ADDR_W >= 3; offsets above 6 select nothing.
module irq_bank_decode
    import irq_bank_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              strobe,
    output reg_sel_t          sel
);

    // Compare address to each offset, gated by the strobe.
    always_comb begin
        sel = SEL_NONE;
        if (strobe) begin
            sel.mode   = (addr == ADDR_W'(OFS_MODE));
            sel.cause  = (addr == ADDR_W'(OFS_CAUSE));
            sel.mcause = (addr == ADDR_W'(OFS_MCAUSE));
            sel.set    = (addr == ADDR_W'(OFS_SET));
            sel.mask   = (addr == ADDR_W'(OFS_MASK));
            sel.mset   = (addr == ADDR_W'(OFS_MSET));
            sel.mclr   = (addr == ADDR_W'(OFS_MCLR));
        end
    end

endmodule

// File: rtl/irq_cause_cell.sv
// Module: irq_cause_cell
// One cause bit. It is set by an event or by software, and cleared by
// a clear request whose kind the mode bit picks. A set beats a clear.
// Assumes a synchronous active-low reset.
module irq_cause_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic mode,      // 0: write-one clear, 1: clear when read
    input  logic evt,
    input  logic sw_set,
    input  logic w1c_hit,
    input  logic cor_hit,
    output logic q,
    output logic d
);

    logic clr;

    // Choose the clear source that the mode bit enables.
    always_comb begin
        clr = mode ? (cor_hit & q) : w1c_hit;
        d   = (q & ~clr) | evt | sw_set;
    end

    // Hold the cause bit.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= d;
    end

endmodule

// File: rtl/irq_bank_ctl.sv
// Module: irq_bank_ctl
// Holds the per-bit clear mode and the mask. The mask has a direct write
// and write-one set/clear aliases. Only one register is written per cycle.
module irq_bank_ctl
    import irq_bank_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  reg_sel_t           wr_sel,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] mode_q,
    output logic [NUM_SRC-1:0] mask_q,
    output logic [NUM_SRC-1:0] mask_d
);

    // Next mask value from the direct write or the aliases.
    always_comb begin
        mask_d = mask_q;
        if (wr_sel.mask)      mask_d = wdata;
        else if (wr_sel.mset) mask_d = mask_q | wdata;
        else if (wr_sel.mclr) mask_d = mask_q & ~wdata;
    end

    // Mask register; resets with every source masked.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '1;
        else        mask_q <= mask_d;
    end

    // Mode register; resets to write-one clear everywhere.
    always_ff @(posedge clk) begin
        if (!rst_n)           mode_q <= '0;
        else if (wr_sel.mode) mode_q <= wdata;
    end

endmodule

// File: rtl/irq_bank_rdmux.sv
// Module: irq_bank_rdmux
// Registered read port. The alias registers and unused offsets read zero.
// Read data holds its value between reads.
module irq_bank_rdmux
    import irq_bank_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  reg_sel_t           rd_sel,
    input  logic [NUM_SRC-1:0] mode_q,
    input  logic [NUM_SRC-1:0] cause_q,
    input  logic [NUM_SRC-1:0] mask_q,
    output logic [NUM_SRC-1:0] rd_data
);

    logic [NUM_SRC-1:0] rd_next;

    // Pick the value of the selected register.
    always_comb begin
        rd_next = '0;
        if (rd_sel.mode)   rd_next = mode_q;
        if (rd_sel.cause)  rd_next = cause_q;
        if (rd_sel.mcause) rd_next = cause_q & ~mask_q;
        if (rd_sel.mask)   rd_next = mask_q;
    end

    // Capture the read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end

endmodule

// File: rtl/irq_cause_bank.sv
// Module: irq_cause_bank (top)
// Interrupt cause/mask bank. It latches event pulses per source, clears
// each bit by its own mode, and drives a registered interrupt from the
// unmasked causes. Assumes one access strobe per cycle and sync reset.
module irq_cause_bank
    import irq_bank_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [NUM_SRC-1:0] wr_data_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    output logic [NUM_SRC-1:0] rd_data_o,
    output logic               irq_o
);

    reg_sel_t           wr_sel;
    reg_sel_t           rd_sel;
    logic [NUM_SRC-1:0] mode_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] mask_d;
    logic [NUM_SRC-1:0] cause_q;
    logic [NUM_SRC-1:0] cause_d;
    logic [NUM_SRC-1:0] w1c_vec;
    logic [NUM_SRC-1:0] cor_vec;
    logic [NUM_SRC-1:0] set_vec;
    logic               irq_q;

    irq_bank_decode #(.ADDR_W(ADDR_W)) u_wdec (
        .addr(addr_i), .strobe(wr_en_i), .sel(wr_sel)
    );

    irq_bank_decode #(.ADDR_W(ADDR_W)) u_rdec (
        .addr(addr_i), .strobe(rd_en_i), .sel(rd_sel)
    );

    irq_bank_ctl #(.NUM_SRC(NUM_SRC)) u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wdata(wr_data_i),
        .mode_q(mode_q), .mask_q(mask_q), .mask_d(mask_d)
    );

    // Per-bit clear and set requests from the access port.
    always_comb begin
        w1c_vec = (wr_sel.cause | wr_sel.mcause) ? wr_data_i : '0;
        cor_vec = rd_sel.cause  ? '1 :
                  rd_sel.mcause ? ~mask_q : '0;
        set_vec = wr_sel.set ? wr_data_i : '0;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
        irq_cause_cell u_cell (
            .clk(clk), .rst_n(rst_n), .mode(mode_q[i]), .evt(evt_i[i]),
            .sw_set(set_vec[i]), .w1c_hit(w1c_vec[i]), .cor_hit(cor_vec[i]),
            .q(cause_q[i]), .d(cause_d[i])
        );
    end

    irq_bank_rdmux #(.NUM_SRC(NUM_SRC)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en_i), .rd_sel(rd_sel),
        .mode_q(mode_q), .cause_q(cause_q), .mask_q(mask_q),
        .rd_data(rd_data_o)
    );

    // Interrupt flop, loaded from next-state values so it tracks the state.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(cause_d & ~mask_d);
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/irq_bank_chk.sv
// Module: irq_bank_chk
// Property checker for irq_cause_bank, bound below.
module irq_bank_chk #(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] evt_i,
    input logic [ADDR_W-1:0]  addr_i,
    input logic [NUM_SRC-1:0] wr_data_i,
    input logic               wr_en_i,
    input logic               rd_en_i,
    input logic [NUM_SRC-1:0] rd_data_o,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] cause_q,
    input logic [NUM_SRC-1:0] mask_q
);

    // R8: an event bit is present in the cause after the next edge.
    a_r8_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        |evt_i |=> ((cause_q & $past(evt_i)) == $past(evt_i)));

    // R9: the interrupt matches the unmasked causes.
    a_r9_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |(cause_q & ~mask_q));

    // R6: a cause-set write raises the written bits.
    a_r6_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_W'(3)) |=>
        ((cause_q & $past(wr_data_i)) == $past(wr_data_i)));

    // R6: the cause-set register reads zero.
    a_r6_set_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == ADDR_W'(3)) |=> rd_data_o == '0);

    // R7: the mask-set alias raises written mask bits.
    a_r7_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_W'(5)) |=>
        ((mask_q & $past(wr_data_i)) == $past(wr_data_i)));

    // R7: the mask-clear alias drops written mask bits.
    a_r7_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_W'(6)) |=>
        ((mask_q & $past(wr_data_i)) == '0));

    // R3: a cause bit rises only from an event or a cause-set write.
    a_r3_no_spurious_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause_q & ~$past(cause_q)) & ~($past(evt_i) |
          ($past(wr_en_i && addr_i == ADDR_W'(3)) ? $past(wr_data_i) : '0))) == '0);

endmodule

bind irq_cause_bank irq_bank_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .addr_i(addr_i),
    .wr_data_i(wr_data_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .rd_data_o(rd_data_o), .irq_o(irq_o), .cause_q(cause_q), .mask_q(mask_q)
);

// File: tb/sim_irq_cause_bank.sv
// Directed bench for irq_cause_bank. Inputs change on falling edges and
// outputs are sampled on falling edges.
module sim_irq_cause_bank;

    localparam int W  = 12;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  evt = '0;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  wdata = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [W-1:0]  rd_data;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_cause_bank #(.NUM_SRC(W), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .addr_i(addr),
        .wr_data_i(wdata), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .rd_data_o(rd_data), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [W-1:0] d);
        addr = AW'(a); wdata = d; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [W-1:0] d);
        addr = AW'(a); rd_en = 1'b1;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic pulse(input logic [W-1:0] e);
        evt = e;
        @(posedge clk); @(negedge clk);
        evt = '0;
    endtask

    task automatic t_reset;
        logic [W-1:0] v;
        check("R2 irq after reset", W'(irq), '0);
        rd(0, v); check("R2 mode reset", v, '0);
        rd(1, v); check("R2 cause reset", v, '0);
        rd(4, v); check("R2 mask reset", v, 12'hFFF);
    endtask

    task automatic t_w1c;
        logic [W-1:0] v;
        pulse(12'h0A5);
        rd(1, v); check("R8 event latched", v, 12'h0A5);
        rd(1, v); check("R4 read keeps mode-0 bits", v, 12'h0A5);
        wr(1, 12'h005);
        rd(1, v); check("R3 w1c partial", v, 12'h0A0);
        wr(1, 12'h0A0);
        rd(1, v); check("R3 w1c rest", v, '0);
    endtask

    task automatic t_cor;
        logic [W-1:0] v;
        wr(0, 12'h0F0);
        rd(0, v); check("R1 mode readback", v, 12'h0F0);
        pulse(12'h0FF);
        wr(1, 12'h0FF);
        rd(1, v); check("R3 write ignores mode-1 bits", v, 12'h0F0);
        rd(1, v); check("R4 read after clear-on-read", v, '0);
        wr(0, 12'h000);
    endtask

    task automatic t_masked;
        logic [W-1:0] v;
        wr(4, 12'h0FF);
        rd(4, v); check("R7 mask direct", v, 12'h0FF);
        pulse(12'h3C3);
        check("R9 irq unmasked cause", W'(irq), 12'h001);
        wr(0, 12'h1C3);
        rd(2, v); check("R5 masked view", v, 12'h300);
        rd(1, v); check("R5 masked read cleared only returned mode-1", v, 12'h2C3);
        rd(1, v); check("R4 raw read cleared mode-1", v, 12'h200);
        wr(2, 12'h200);
        rd(1, v); check("R3 w1c through masked view", v, '0);
        check("R9 irq low", W'(irq), '0);
        wr(0, 12'h000);
    endtask

    task automatic t_set_alias;
        logic [W-1:0] v;
        wr(3, 12'h801);
        rd(1, v); check("R6 set alias", v, 12'h801);
        rd(3, v); check("R6 set alias reads zero", v, '0);
        check("R9 irq from sw set", W'(irq), 12'h001);
        wr(1, 12'h801);
    endtask

    task automatic t_mask_alias;
        logic [W-1:0] v;
        wr(5, 12'hF00);
        rd(4, v); check("R7 mask set alias", v, 12'hFFF);
        wr(6, 12'h011);
        rd(4, v); check("R7 mask clear alias", v, 12'hFEE);
        rd(5, v); check("R7 mask set reads zero", v, '0);
        rd(6, v); check("R7 mask clear reads zero", v, '0);
        wr(3, 12'h010);
        check("R9 irq on unmasked bit", W'(irq), 12'h001);
        wr(5, 12'h010);
        check("R9 irq drops when masked", W'(irq), '0);
        rd(1, v); check("R7 masked cause kept", v, 12'h010);
        wr(1, 12'h010);
    endtask

    task automatic t_collision;
        logic [W-1:0] v;
        wr(3, 12'h006);
        addr = AW'(1); wdata = 12'h006; wr_en = 1'b1; evt = 12'h004;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; evt = '0;
        rd(1, v); check("R8 event beats write clear", v, 12'h004);
        wr(0, 12'h004);
        addr = AW'(1); rd_en = 1'b1; evt = 12'h004;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0; evt = '0;
        check("R10 read data next cycle", rd_data, 12'h004);
        rd(1, v); check("R8 event beats read clear", v, 12'h004);
        rd(1, v); check("R4 cleared after read", v, '0);
        wr(0, 12'h000);
    endtask

    task automatic t_unused;
        logic [W-1:0] v;
        wr(3, 12'h00F);
        rd(7, v); check("R10 offset 7 reads zero", v, '0);
        rd(9, v); check("R10 offset 9 reads zero", v, '0);
        rd(1, v); check("R10 unused reads leave cause", v, 12'h00F);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_w1c();
        t_cor();
        t_masked();
        t_set_alias();
        t_mask_alias();
        t_collision();
        t_unused();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule